// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Port

This block holds a colour palette for a display pipeline: 256 main entries and 4 overlay entries that draw the hardware cursor, each a 24-bit red/green/blue triple. Software reaches the table through a 16-byte window of 32-bit registers. One register sets a shared entry pointer. Two data registers then move one colour component per access, stepping red, green, blue. The main data register writes the main entry under the pointer. The overlay data register writes the overlay entry chosen by the pointer's two low bits. The remaining slot stands for control registers: writes to it are accepted and dropped.

Both reads and writes advance the same three-phase sequencer, and the pointer moves on only after the blue step. The pixel side has its own combinational lookup port. It takes a 9-bit entry number (0..255 main, 256..259 overlay) and returns the stored triple.

Register requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each read that is taken produces one response word, which stays on `rsp_rdata` with `rsp_valid` high until a cycle with `rsp_ready` high. While a response waits, `req_ready` is low and no new request is taken. Writes produce no response.

Top module: `pal_dac`

## Requirements
- R1: After reset the pointer is 0, the phase is red, and every entry reads 0x000000 except entries 255, 256 and 258, which read 0xFFFFFF.
- R2: A full write at offset 0 loads the pointer from data bits 31:24 and returns the phase to red.
- R3: Full writes at offset 4 store data bits 31:24 into the red, then green, then blue component of main entry `pointer`; bits 23:0 are not used.
- R4: Only a blue-phase data access advances the pointer, by one modulo 256, so 255 wraps to 0.
- R5: Full writes at offset 12 go to overlay entry 256 + (pointer mod 4), using the same phase sequence and pointer advance as main writes.
- R6: A full read at offset 4 or 12 returns the current-phase component of main entry `pointer` in bits 31:24 with bits 23:0 zero, and advances the same sequencer that writes use.
- R7: A write at offset 8, or at any address that is not 4-byte aligned, changes no entry, pointer or phase; a read at offset 0 or 8 returns 0 and changes nothing.
- R8: Any access whose byte enables are not all four set changes no entry, pointer or phase; a read of this kind still gets a response, with value 0.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold, `req_ready` is low, and a waiting request has no effect.
- R10: `lut_rgb` gives red in bits 23:16, green in 15:8 and blue in 7:0 of entry `lut_idx` in the same cycle; numbers 260 and above give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset in the register window |
| req_be | input | 4 | Byte enables; only 4'hF accesses act |
| req_wdata | input | 32 | Write data, component in bits 31:24 |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, component in bits 31:24 |
| lut_idx | input | 9 | Pixel-side entry number |
| lut_rgb | output | 24 | Pixel-side colour of that entry |

## Verification
The checks that run on every cycle cover the sequencer and the response channel. The phase always holds a legal value. A pointer load forces red. A blue step moves the pointer by one, and a red or green step leaves it alone. A control-slot write leaves pointer and phase untouched. A stalled response holds steady, with its low 24 bits zero. Only the directed scenarios can show which entry a write actually lands in: the overlay redirection, the wrap from 255 to 0, the reset colours, and the fact that reads and writes share one phase. The same holds for showing that rejected accesses and requests blocked by a stalled response leave the table unchanged.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

  // Sequencer position: which colour component the next data access moves
  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  // Register slot, decoded from address bits 3:2
  typedef enum logic [1:0] {
    SLOT_PTR  = 2'd0,
    SLOT_MAIN = 2'd1,
    SLOT_CTRL = 2'd2,
    SLOT_OVL  = 2'd3
  } slot_e;

  // Entries that come out of reset white: last main entry, overlay 0, overlay 2
  function automatic logic reset_white(input int unsigned entry, input int unsigned main_n);
    return (entry == main_n - 1) || (entry == main_n) || (entry == main_n + 2);
  endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      unique case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  // R4
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase inside {PH_RED, PH_GREEN, PH_BLUE});

  // R2
  load_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phase == PH_RED) && (idx == $past(load_val)));

  // R4
  blue_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && phase == PH_BLUE) |=> (idx == $past(idx) + 1'b1) && (phase == PH_RED));

  // R4
  rg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && phase != PH_BLUE) |=> $stable(idx));

endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_dac_pkg::*;
#(
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  parameter int COMP_W = 8,
  parameter int ENT_W  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ENT_W-1:0]    wr_entry,
  input  phase_e              wr_phase,
  input  logic [COMP_W-1:0]   wr_comp,
  input  logic [ENT_W-1:0]    rd_entry,
  output logic [3*COMP_W-1:0] rd_rgb,
  input  logic [ENT_W-1:0]    lut_entry,
  output logic [3*COMP_W-1:0] lut_rgb
);

  localparam int TOTAL = MAIN_N + OVL_N;
  localparam int RGB_W = 3 * COMP_W;

  logic [RGB_W-1:0] mem [TOTAL];
  logic [$clog2(RGB_W)-1:0] top_bit;

  // Red sits in the top field, blue in the bottom one
  always_comb begin
    unique case (wr_phase)
      PH_RED:   top_bit = RGB_W - 1;
      PH_GREEN: top_bit = 2 * COMP_W - 1;
      default:  top_bit = COMP_W - 1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < TOTAL; e++) begin
        mem[e] <= reset_white(e, MAIN_N) ? {RGB_W{1'b1}} : '0;
      end
    end else if (wr_en && (int'(wr_entry) < TOTAL)) begin
      mem[wr_entry][top_bit -: COMP_W] <= wr_comp;
    end
  end

  // Port widths may exceed the table; out-of-range numbers read as black
  generate
    if ((1 << ENT_W) > TOTAL) begin : g_guard
      assign rd_rgb  = (int'(rd_entry) < TOTAL)  ? mem[rd_entry]  : '0;
      assign lut_rgb = (int'(lut_entry) < TOTAL) ? mem[lut_entry] : '0;
    end else begin : g_exact
      assign rd_rgb  = mem[rd_entry];
      assign lut_rgb = mem[lut_entry];
    end
  endgenerate

endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
#(
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [$clog2(MAIN_N):0] lut_idx,
  output logic [3*COMP_W-1:0]     lut_rgb
);

  localparam int IDX_W = $clog2(MAIN_N);
  localparam int ENT_W = IDX_W + 1;
  localparam int OVL_W = (OVL_N > 1) ? $clog2(OVL_N) : 1;
  localparam int RGB_W = 3 * COMP_W;
  localparam int PAD_W = DATA_W - COMP_W;

  logic              take, in_win, act;
  slot_e             slot;
  logic              ptr_load, data_acc, wr_en;
  logic [IDX_W-1:0]  ptr;
  phase_e            phase;
  logic [ENT_W-1:0]  wr_entry;
  logic [COMP_W-1:0] wr_comp, rd_comp;
  logic [RGB_W-1:0]  rd_rgb;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  generate
    if (ADDR_W > 4) begin : g_win
      assign in_win = (req_addr[ADDR_W-1:4] == '0);
    end else begin : g_nowin
      assign in_win = 1'b1;
    end
  endgenerate

  // Only aligned, full-width accesses inside the window have any effect
  assign act      = take && (&req_be) && (req_addr[1:0] == 2'b00) && in_win;
  assign slot     = slot_e'(req_addr[3:2]);
  assign ptr_load = act && req_write && (slot == SLOT_PTR);
  assign data_acc = act && ((slot == SLOT_MAIN) || (slot == SLOT_OVL));
  assign wr_en    = data_acc && req_write;
  assign wr_comp  = req_wdata[DATA_W-1 -: COMP_W];

  // Overlay writes pick their entry from the low pointer bits
  always_comb begin
    if (slot == SLOT_OVL) begin
      wr_entry = ENT_W'(MAIN_N) + ENT_W'(ptr[OVL_W-1:0]);
    end else begin
      wr_entry = ENT_W'(ptr);
    end
  end

  pal_seq #(
    .IDX_W (IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (req_wdata[DATA_W-1 -: IDX_W]),
    .step     (data_acc),
    .idx      (ptr),
    .phase    (phase)
  );

  pal_store #(
    .MAIN_N (MAIN_N),
    .OVL_N  (OVL_N),
    .COMP_W (COMP_W),
    .ENT_W  (ENT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_entry  (wr_entry),
    .wr_phase  (phase),
    .wr_comp   (wr_comp),
    .rd_entry  (ENT_W'(ptr)),
    .rd_rgb    (rd_rgb),
    .lut_entry (lut_idx),
    .lut_rgb   (lut_rgb)
  );

  always_comb begin
    unique case (phase)
      PH_RED:   rd_comp = rd_rgb[RGB_W-1 -: COMP_W];
      PH_GREEN: rd_comp = rd_rgb[2*COMP_W-1 -: COMP_W];
      default:  rd_comp = rd_rgb[COMP_W-1:0];
    endcase
  end

  // Response register: one word per taken read, held until consumed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= data_acc ? {rd_comp, {PAD_W{1'b0}}} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  // R6
  rsp_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[PAD_W-1:0] == '0));

  // R7
  ctrl_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot == SLOT_CTRL) |=> $stable(ptr) && $stable(phase));

  // R8
  partial_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(&req_be)) |=> $stable(ptr) && $stable(phase));

endmodule

// File: tb/pal_dac_bench.sv
module pal_dac_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [8:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_dac u_pal_dac (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .lut_idx   (lut_idx),
    .lut_rgb   (lut_rgb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_be = 4'hF;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_be = 4'hF;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
  endtask

  task automatic look(input logic [8:0] e, output logic [23:0] v);
    lut_idx = e;
    #1;
    v = lut_rgb;
  endtask

  task automatic t_reset;
    logic [23:0] v;
    logic [31:0] d;
    look(9'd0,   v); chk("R1 entry0",   {8'h0, v}, 32'h0);
    look(9'd255, v); chk("R1 entry255", {8'h0, v}, 32'hFFFFFF);
    look(9'd256, v); chk("R1 entry256", {8'h0, v}, 32'hFFFFFF);
    look(9'd257, v); chk("R1 entry257", {8'h0, v}, 32'h0);
    look(9'd258, v); chk("R1 entry258", {8'h0, v}, 32'hFFFFFF);
    look(9'd259, v); chk("R1 entry259", {8'h0, v}, 32'h0);
    chk("R1 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
    rd(4'd4, d); chk("R1 pointer 0 red", d, 32'h0);
  endtask

  task automatic t_main_write;
    logic [23:0] v;
    wr(4'd0, 32'h0A00_0000);
    wr(4'd4, 32'h11AB_CDEF);
    wr(4'd4, 32'h2212_3456);
    wr(4'd4, 32'h33FF_FFFF);
    look(9'd10, v); chk("R3 entry10", {8'h0, v}, 32'h112233);
    wr(4'd4, 32'h4400_0000);
    look(9'd11, v); chk("R4 advance to 11", {8'h0, v}, 32'h440000);
    wr(4'd4, 32'h5500_0000);
    wr(4'd4, 32'h6600_0000);
    look(9'd11, v); chk("R3 entry11", {8'h0, v}, 32'h445566);
  endtask

  task automatic t_wrap;
    logic [23:0] v;
    wr(4'd0, 32'hFF00_0000);
    wr(4'd4, 32'h0100_0000);
    wr(4'd4, 32'h0200_0000);
    wr(4'd4, 32'h0300_0000);
    look(9'd255, v); chk("R4 entry255", {8'h0, v}, 32'h010203);
    wr(4'd4, 32'h0900_0000);
    look(9'd0, v); chk("R4 wrap to 0", {8'h0, v}, 32'h090000);
    look(9'd256, v); chk("R4 no spill to 256", {8'h0, v}, 32'hFFFFFF);
  endtask

  task automatic t_overlay;
    logic [23:0] v;
    wr(4'd0, 32'h0600_0000);
    wr(4'd12, 32'hA100_0000);
    wr(4'd12, 32'hA200_0000);
    wr(4'd12, 32'hA300_0000);
    look(9'd258, v); chk("R5 overlay 2", {8'h0, v}, 32'hA1A2A3);
    look(9'd6, v);   chk("R5 main 6 untouched", {8'h0, v}, 32'h0);
    wr(4'd12, 32'hB000_0000);
    look(9'd259, v); chk("R5 overlay 3 after advance", {8'h0, v}, 32'hB00000);
    wr(4'd0, 32'h2000_0000);
    wr(4'd4, 32'hC000_0000);
    look(9'd32, v); chk("R2 phase back to red", {8'h0, v}, 32'hC00000);
  endtask

  task automatic t_read_seq;
    logic [31:0] d;
    logic [23:0] v;
    wr(4'd0, 32'h0A00_0000);
    rd(4'd4,  d); chk("R6 red",   d, 32'h1100_0000);
    rd(4'd12, d); chk("R6 green", d, 32'h2200_0000);
    rd(4'd4,  d); chk("R6 blue",  d, 32'h3300_0000);
    rd(4'd4,  d); chk("R6 next entry red", d, 32'h4400_0000);
    wr(4'd0, 32'h0A00_0000);
    wr(4'd4, 32'h7700_0000);
    rd(4'd4, d); chk("R6 shared phase", d, 32'h2200_0000);
    look(9'd10, v); chk("R6 entry10 red", {8'h0, v}, 32'h772233);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    logic [23:0] v;
    wr(4'd0, 32'h0C00_0000);
    wr(4'd8, 32'hEE00_0000);
    wr(4'd1, 32'hEE00_0000);
    wr(4'd4, 32'h5A00_0000);
    look(9'd12, v); chk("R7 ctrl write inert", {8'h0, v}, 32'h5A0000);
    rd(4'd8, d); chk("R7 ctrl read zero", d, 32'h0);
    rd(4'd0, d); chk("R7 pointer read zero", d, 32'h0);
    wr(4'd4, 32'h5B00_0000);
    look(9'd12, v); chk("R7 phase kept", {8'h0, v}, 32'h5A5B00);
  endtask

  task automatic t_partial;
    logic [31:0] d;
    logic [23:0] v;
    wr(4'd0, 32'h3000_0000, 4'h8);
    wr(4'd4, 32'hFF00_0000, 4'h7);
    look(9'd12, v); chk("R8 partial write inert", {8'h0, v}, 32'h5A5B00);
    rd(4'd4, d, 4'hE); chk("R8 partial read zero", d, 32'h0);
    wr(4'd4, 32'h5C00_0000);
    look(9'd12, v); chk("R8 blue lands on 12", {8'h0, v}, 32'h5A5B5C);
    look(9'd48, v); chk("R8 no pointer load", {8'h0, v}, 32'h0);
  endtask

  task automatic t_stall;
    logic [31:0] d, held;
    wr(4'd0, 32'h0A00_0000);
    rsp_ready = 1'b0;
    rd(4'd4, d); chk("R9 stalled data", d, 32'h7700_0000);
    held = d;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd0; req_wdata = 32'h5500_0000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 ready low", {31'h0, req_ready}, 32'h0);
      chk("R9 data held", rsp_rdata, held);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 response consumed", {31'h0, rsp_valid}, 32'h0);
    rd(4'd4, d); chk("R9 blocked write had no effect", d, 32'h2200_0000);
  endtask

  task automatic t_lut_range;
    logic [23:0] v;
    look(9'd260, v); chk("R10 entry260", {8'h0, v}, 32'h0);
    look(9'd511, v); chk("R10 entry511", {8'h0, v}, 32'h0);
    look(9'd10,  v); chk("R10 field order", {8'h0, v}, 32'h772233);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_main_write();
    t_wrap();
    t_overlay();
    t_read_seq();
    t_ignored();
    t_partial();
    t_stall();
    t_lut_range();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule